// File: doc/BRIEF.md
# Burst Read Stall Indicator Generator

This block sits on the device side of a synchronous, burst-capable parallel memory bus and produces the stall indicator that tells the host when read data is not yet valid. It watches the chip-enable, output-enable, write-enable and address-valid strobes. It also holds a small configuration register that selects the read mode (synchronous or asynchronous), the active level of the stall indicator and the initial read latency. When the host latches an address in synchronous mode, an internal counter holds the stall indicator asserted for the programmed number of clock edges. After that the indicator stays deasserted while the block presents one data word per clock until the chip is deselected.

The memory behind the bus is modelled behaviourally. Array reads return a word counter that starts at the latched address and increments once per clock. Non-array reads (status, identifier, query) return a fixed identification word. The stall pin is tri-stated unless the chip and its outputs are both enabled. Its level is registered and changes only at clock edges inside an active bus cycle. The bus reset pin resets the block asynchronously, and release is synchronized internally.

Top module: `wg_burst_wait`

## Requirements
- R1: `stall_oe` is 1 exactly when `chip_en_n` and `out_en_n` are both 0, and 0 otherwise, with no clock delay.
- R2: While `bus_rst_n` is low, and afterwards until the configuration is first written, the block is in asynchronous mode with an active-high stall level, so `stall_o` reads 0 during reads.
- R3: A configuration word on `cfg_wdata` is captured at the rising edge where `cfg_we` is 1. Bit 15 selects the mode (0 = synchronous, 1 = asynchronous), bit 10 the stall polarity (1 = active-high, 0 = active-low), and bits 13:11 the latency code.
- R4: In asynchronous mode, `stall_o` goes to the deasserted level (the inverse of the polarity bit) at the first active clock edge and stays there.
- R5: In synchronous mode, call the edge where `chip_en_n` and `addr_vld_n` are both 0 edge 0. The stall is asserted after edges 0 to L-1 and deasserted from edge L onward, where L is the latency code and code 0 means 8.
- R6: Once deasserted, the stall stays deasserted and array data advances by one per clock until `chip_en_n` rises. Deselection clears the burst, so the next latch starts a fresh latency count.
- R7: From edge L, `dq_out` equals the latched address for an array read (`rd_space`=0), incrementing modulo 2^16 each edge. For a non-array read (`rd_space`=1) it stays at the identification word 16'h0089. `dq_oe` follows the same enable rule as `stall_oe`.
- R8: While `wr_en_n` is 0 during an active bus cycle, the stall is driven to the deasserted level at the next clock edge.
- R9: `stall_o` changes only at rising clock edges where `chip_en_n` and `out_en_n` were both 0. With outputs disabled it holds its last value even while the latency counter expires.
- R10: The asserted stall level equals the polarity bit: 1 for active-high, 0 for active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| addr_vld_n | input | 1 | Address-valid strobe, active low, latches `addr` |
| addr | input | 16 | Start address of a burst |
| rd_space | input | 1 | 0 = array read, 1 = non-array read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Read data drive enable |
| stall_o | output | 1 | Stall indicator level |
| stall_oe | output | 1 | Stall pin drive enable |

## Verification
The stall register can see, at one edge, both the expiry of the latency counter and a change in whether the bus cycle is active. Examples are the output enable being withdrawn while the count runs out, or a write strobe arriving while the latency is still pending. The bench causes the first by raising `out_en_n` right after the latch and holding it past the expiry edge, and the second by pulling `wr_en_n` low mid-latency. In both cases it judges the pin against the level the rules predict per edge: held, forced to the deasserted level, then re-asserted or released once the cycle is active again. A full sweep over polarity, mode, all eight latency codes and both read spaces checks the pin level, both enables and the data word on every cycle of every burst.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int CFG_W    = 16;
  localparam int MODE_BIT = 15;
  localparam int POL_BIT  = 10;
  localparam int LAT_LSB  = 11;
  localparam int LAT_W    = 3;
  localparam int CNT_W    = LAT_W + 1;

  typedef struct packed {
    logic             async_md;
    logic             pol_hi;
    logic [LAT_W-1:0] lat;
  } wg_cfg_t;

  localparam wg_cfg_t CFG_DEFAULT = '{async_md: 1'b1, pol_hi: 1'b1, lat: 3'd4};

  // latency code to edge count; zero selects the longest setting
  function automatic logic [CNT_W-1:0] eff_lat(input logic [LAT_W-1:0] code);
    if (code == '0) return CNT_W'(1 << LAT_W);
    else            return CNT_W'(code);
  endfunction

  function automatic wg_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    wg_cfg_t c;
    c.async_md = w[MODE_BIT];
    c.pol_hi   = w[POL_BIT];
    c.lat      = w[LAT_LSB +: LAT_W];
    return c;
  endfunction
endpackage

// File: rtl/wg_rst_sync.sv
module wg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/wg_cfg_reg.sv
module wg_cfg_reg
  import wg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output wg_cfg_t          cfg_o
);
  wg_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = decode_cfg(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_DEFAULT;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/wg_lat_ctr.sv
module wg_lat_ctr
  import wg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en_n,
  input  logic             addr_vld_n,
  input  logic [LAT_W-1:0] lat_code,
  output logic             vld_o,
  output logic             vld_next_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (chip_en_n) begin
      cnt_d = '0;
      vld_d = 1'b0;
    end else if (!addr_vld_n) begin
      cnt_d = eff_lat(lat_code);
      vld_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign vld_o      = vld_q;
  assign vld_next_o = vld_d;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/wg_data_src.sv
module wg_data_src #(
  parameter int          DW      = 16,
  parameter logic [15:0] NA_WORD = 16'h0089
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_en_n,
  input  logic          out_en_n,
  input  logic          addr_vld_n,
  input  logic [DW-1:0] addr,
  input  logic          rd_space,
  input  logic          vld,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          space_o
);
  logic [DW-1:0] ptr_q, ptr_d;
  logic          space_q, space_d;

  always_comb begin
    ptr_d   = ptr_q;
    space_d = space_q;
    if (!chip_en_n && !addr_vld_n) begin
      ptr_d   = addr;
      space_d = rd_space;
    end else if (!chip_en_n && vld) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      space_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      space_q <= space_d;
    end
  end

  assign dq_out  = space_q ? DW'(NA_WORD) : ptr_q;
  assign dq_oe   = ~chip_en_n & ~out_en_n;
  assign space_o = space_q;
endmodule

// File: rtl/wg_stall_drv.sv
module wg_stall_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en_n,
  input  logic out_en_n,
  input  logic wr_en_n,
  input  logic async_md,
  input  logic pol_hi,
  input  logic vld_next,
  output logic stall_o,
  output logic stall_oe
);
  logic active;
  logic want_stall;
  logic lvl_q, lvl_d;

  always_comb begin
    active     = ~chip_en_n & ~out_en_n;
    want_stall = ~async_md & wr_en_n & ~vld_next;
    lvl_d      = lvl_q;
    if (active) lvl_d = pol_hi ? want_stall : ~want_stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign stall_o  = lvl_q;
  assign stall_oe = active;
endmodule

// File: rtl/wg_burst_wait.sv
module wg_burst_wait
  import wg_pkg::*;
#(
  parameter int          DW          = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] NA_WORD     = 16'h0089
) (
  input  logic          clk,
  input  logic          bus_rst_n,
  input  logic          chip_en_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic          addr_vld_n,
  input  logic [DW-1:0] addr,
  input  logic          rd_space,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          stall_o,
  output logic          stall_oe
);
  logic             rst_sync_n;
  wg_cfg_t          cfg_q;
  logic             lat_vld;
  logic             lat_vld_next;
  logic [CNT_W-1:0] lat_cnt;
  logic             data_space;

  wg_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk(clk), .arst_n(bus_rst_n), .rst_n_o(rst_sync_n)
  );

  wg_cfg_reg cfg_i (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_we),
    .wr_data(CFG_W'(cfg_wdata)), .cfg_o(cfg_q)
  );

  wg_lat_ctr lat_i (
    .clk(clk), .rst_n(rst_sync_n), .chip_en_n(chip_en_n),
    .addr_vld_n(addr_vld_n), .lat_code(cfg_q.lat),
    .vld_o(lat_vld), .vld_next_o(lat_vld_next), .cnt_o(lat_cnt)
  );

  wg_data_src #(.DW(DW), .NA_WORD(NA_WORD)) data_i (
    .clk(clk), .rst_n(rst_sync_n), .chip_en_n(chip_en_n),
    .out_en_n(out_en_n), .addr_vld_n(addr_vld_n), .addr(addr),
    .rd_space(rd_space), .vld(lat_vld), .dq_out(dq_out),
    .dq_oe(dq_oe), .space_o(data_space)
  );

  wg_stall_drv stall_i (
    .clk(clk), .rst_n(rst_sync_n), .chip_en_n(chip_en_n),
    .out_en_n(out_en_n), .wr_en_n(wr_en_n), .async_md(cfg_q.async_md),
    .pol_hi(cfg_q.pol_hi), .vld_next(lat_vld_next),
    .stall_o(stall_o), .stall_oe(stall_oe)
  );
endmodule

// File: rtl/wg_burst_wait_chk.sv
module wg_burst_wait_chk
  import wg_pkg::*;
#(
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_en_n,
  input logic             out_en_n,
  input logic             wr_en_n,
  input logic             addr_vld_n,
  input logic             stall_o,
  input logic             stall_oe,
  input logic             async_md,
  input logic             pol_hi,
  input logic             vld,
  input logic             space,
  input logic [CNT_W-1:0] cnt,
  input logic [DW-1:0]    dq_out
);
  // R1
  tri_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en_n || out_en_n) |-> !stall_oe);

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(!chip_en_n && !out_en_n) |-> $stable(stall_o));

  // R4
  async_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!chip_en_n && !out_en_n && async_md) && $stable(pol_hi)) |-> (stall_o == !pol_hi));

  // R8
  write_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!chip_en_n && !out_en_n && !wr_en_n) && $stable(pol_hi)) |-> (stall_o == !pol_hi));

  // R10
  sync_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!chip_en_n && !out_en_n && wr_en_n && !async_md) && $stable(pol_hi))
      |-> ((stall_o == pol_hi) == !vld));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(1 << LAT_W));

  // R5
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld) |-> ($past(cnt) == CNT_W'(1)));

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vld && !chip_en_n && addr_vld_n) && !space) |-> ((dq_out - $past(dq_out)) == DW'(1)));
endmodule

bind wg_burst_wait wg_burst_wait_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
  .wr_en_n(wr_en_n), .addr_vld_n(addr_vld_n), .stall_o(stall_o),
  .stall_oe(stall_oe), .async_md(cfg_q.async_md), .pol_hi(cfg_q.pol_hi),
  .vld(lat_vld), .space(data_space), .cnt(lat_cnt), .dq_out(dq_out)
);

// File: tb/wg_burst_wait_tb_top.sv
module wg_burst_wait_tb_top;
  localparam logic [15:0] NA = 16'h0089;

  logic        clk;
  logic        bus_rst_n;
  logic        chip_en_n, out_en_n, wr_en_n, addr_vld_n;
  logic [15:0] addr;
  logic        rd_space;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic [15:0] dq_out;
  logic        dq_oe, stall_o, stall_oe;

  int errors = 0;
  int total  = 0;
  bit done   = 0;

  wg_burst_wait dut_i (
    .clk(clk), .bus_rst_n(bus_rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .addr_vld_n(addr_vld_n), .addr(addr), .rd_space(rd_space),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .dq_out(dq_out), .dq_oe(dq_oe),
    .stall_o(stall_o), .stall_oe(stall_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R3: bit 15 mode, bits 13:11 latency code, bit 10 polarity
  function automatic logic [15:0] cfg_word(input bit pol, input bit async_m, input int code);
    return (16'(async_m) << 15) | (16'(code) << 11) | (16'(pol) << 10);
  endfunction

  task automatic run_burst(input bit pol, input bit async_m, input int code, input bit space);
    int leff;
    logic [15:0] base;
    bit exp_assert;
    leff = (code == 0) ? 8 : code;
    base = 16'hFFFC + 16'(code);
    cfg_write(cfg_word(pol, async_m, code));
    chk("R1 idle stall_oe", 32'(stall_oe), 0);
    @(negedge clk);
    chip_en_n = 1'b0; out_en_n = 1'b0; addr_vld_n = 1'b0;
    addr = base; rd_space = space;
    for (int k = 0; k < leff + 4; k++) begin
      @(negedge clk);
      addr_vld_n = 1'b1;
      chk("R1 active stall_oe", 32'(stall_oe), 1);
      chk("R7 dq_oe", 32'(dq_oe), 1);
      exp_assert = !async_m && (k < leff);
      if (async_m) chk("R4 async level", 32'(stall_o), 32'(!pol));
      else chk("R3/R5/R10 sync level", 32'(stall_o), 32'(pol ? exp_assert : !exp_assert));
      if (!async_m && k >= leff)
        chk("R6/R7 data word", 32'(dq_out), space ? 32'(NA) : 32'(16'(base + 16'(k - leff))));
    end
    chip_en_n = 1'b1; out_en_n = 1'b1;
    #1;
    chk("R1 deselect stall_oe", 32'(stall_oe), 0);
    chk("R1 deselect dq_oe", 32'(dq_oe), 0);
  endtask

  initial begin
    chip_en_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1; addr_vld_n = 1'b1;
    addr = '0; rd_space = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    bus_rst_n = 1'b1;
    #1 bus_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset stall_o", 32'(stall_o), 0);
    chk("R1 reset stall_oe", 32'(stall_oe), 0);
    bus_rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: default is asynchronous, active-high, so the pin reads 0
    chip_en_n = 1'b0; out_en_n = 1'b0; addr_vld_n = 1'b0; addr = 16'h0040;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      addr_vld_n = 1'b1;
      chk("R2 default async level", 32'(stall_o), 0);
    end
    chip_en_n = 1'b1; out_en_n = 1'b1;

    // sweep: polarity, mode, latency code, read space
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 8; c++)
          for (int s = 0; s < 2; s++)
            run_burst(bit'(p), bit'(m), c, bit'(s));

    // R9: output enable withdrawn across latency expiry
    cfg_write(cfg_word(1'b1, 1'b0, 4));
    @(negedge clk);
    chip_en_n = 1'b0; out_en_n = 1'b0; addr_vld_n = 1'b0; addr = 16'h0100; rd_space = 1'b0;
    @(negedge clk);
    addr_vld_n = 1'b1;
    chk("R9 asserted at latch", 32'(stall_o), 1);
    out_en_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 held while outputs off", 32'(stall_o), 1);
    chk("R1 oe off stall_oe", 32'(stall_oe), 0);
    out_en_n = 1'b0;
    @(negedge clk);
    chk("R9/R6 released on active edge", 32'(stall_o), 0);
    chip_en_n = 1'b1; out_en_n = 1'b1;

    // R8: write strobe during latency
    cfg_write(cfg_word(1'b1, 1'b0, 5));
    @(negedge clk);
    chip_en_n = 1'b0; out_en_n = 1'b0; addr_vld_n = 1'b0; addr = 16'h0200;
    @(negedge clk);
    addr_vld_n = 1'b1;
    chk("R8 asserted before write", 32'(stall_o), 1);
    wr_en_n = 1'b0;
    @(negedge clk);
    chk("R8 deasserted during write", 32'(stall_o), 0);
    wr_en_n = 1'b1;
    @(negedge clk);
    chk("R8 re-asserted after write", 32'(stall_o), 1);
    chip_en_n = 1'b1; out_en_n = 1'b1;

    // R8 with active-low polarity
    cfg_write(cfg_word(1'b0, 1'b0, 6));
    @(negedge clk);
    chip_en_n = 1'b0; out_en_n = 1'b0; addr_vld_n = 1'b0;
    @(negedge clk);
    addr_vld_n = 1'b1;
    chk("R10 active-low asserted", 32'(stall_o), 0);
    wr_en_n = 1'b0;
    @(negedge clk);
    chk("R8 active-low write level", 32'(stall_o), 1);
    wr_en_n = 1'b1;
    chip_en_n = 1'b1; out_en_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end
endmodule